// File: doc/BRIEF.md
# Burst Address Load and Advance Unit

This unit is the address front end of a synchronous burst memory. On a rising clock edge it captures a new word address from either of two active-low address strobes. The cache-side strobe loads on its own. The processor-side strobe loads only while chip enable is low. It also records whether the device is selected, sampling the three select inputs on the same edge that loads the address.

After a load, an active-low advance input steps the address through a four-beat burst. Only the low two bits take part in the burst. A static order input chooses the step pattern:
- Linear order counts upward and wraps.
- Interleaved order XORs the starting low bits with a running beat count.

A sleep input freezes every register. The memory array reads the current word address and the selected flag directly from the unit's outputs.

Top module: `burst_addr_unit`

## Requirements
- R1: With `cache_stb_n` low on a rising edge, `addr_o` shows `addr_i` after that edge, whatever the level of `ce_n`.
- R2: `proc_stb_n` low loads `addr_i` only when `ce_n` is also low. With `ce_n` high and `cache_stb_n` high, `proc_stb_n` low leaves `addr_o` unchanged while `adv_n` is high.
- R3: On an edge with no effective strobe, `adv_n` low advances the burst by one beat. `adv_n` high leaves `addr_o` unchanged.
- R4: With `order_i` = 0 (linear), each advance adds 1 modulo 4 to `addr_o[1:0]`, and `addr_o[16:2]` keeps its loaded value.
- R5: With `order_i` = 1 (interleaved), after k advances `addr_o[1:0]` equals the loaded low two bits XOR (k mod 4). For example, a start of 1 gives 1, 0, 3, 2.
- R6: The advance that follows the fourth beat returns the address to the loaded start value, in both orders.
- R7: `selected_o` is updated only on a load edge. It becomes 1 exactly when `ce_n` = 0, `cs_hi_i` = 1 and `cs_lo_n` = 0 on that edge, and it is held through advances and idle edges.
- R8: When both strobes are low on the same edge, one load takes place and the beat count restarts at 0. A load edge ignores `adv_n`, so the new address appears unadvanced.
- R9: While `sleep_i` is high, no strobe, advance or select input changes `addr_o` or `selected_o`.
- R10: A synchronous active-high `rst` sets `addr_o` to 0 and `selected_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Holds all state while high |
| cache_stb_n | input | 1 | Cache-side address strobe, active low |
| proc_stb_n | input | 1 | Processor-side address strobe, active low, qualified by `ce_n` |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi_i | input | 1 | Select input, active high |
| cs_lo_n | input | 1 | Select input, active low |
| order_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_i | input | 17 | Address presented for loading |
| addr_o | output | 17 | Current word address to the array |
| selected_o | output | 1 | Device selected, captured at the last load |

## Verification
A load and an advance can be requested on the same edge. The bench provokes this by driving both strobes low together with `adv_n` low, after an address has already been advanced once. The next sampled address must equal the newly presented one with no step applied. The following advance must then continue from beat 0 of that new address.

Sleep can also coincide with any other request. The bench raises `sleep_i` while presenting a strobe, an advance and a changed select, and expects both outputs to keep their prior values.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic advance;
        logic sel;
    } step_ctrl_t;

    function automatic logic chip_selected(input logic ce_n,
                                           input logic cs_hi,
                                           input logic cs_lo_n);
        return !ce_n && cs_hi && !cs_lo_n;
    endfunction

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
    import burst_addr_pkg::*;
(
    input  logic       sleep_i,
    input  logic       cache_stb_n,
    input  logic       proc_stb_n,
    input  logic       adv_n,
    input  logic       ce_n,
    input  logic       cs_hi_i,
    input  logic       cs_lo_n,
    output step_ctrl_t ctrl_o
);
    logic cache_req;
    logic proc_req;

    always_comb begin
        cache_req      = !cache_stb_n;
        proc_req       = !proc_stb_n && !ce_n;
        ctrl_o.load    = !sleep_i && (cache_req || proc_req);
        ctrl_o.advance = !sleep_i && !ctrl_o.load && !adv_n;
        ctrl_o.sel     = chip_selected(ce_n, cs_hi_i, cs_lo_n);
    end

    always_comb begin
        if (ctrl_o.load && ctrl_o.advance)
            $error("load and advance overlap (r8)");
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_addr_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic                  advance_i,
    input  logic [BURST_BITS-1:0] start_i,
    input  order_e                order_i,
    output logic [BURST_BITS-1:0] low_o
);
    logic [BURST_BITS-1:0] start_q;
    logic [BURST_BITS-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (load_i) begin
            start_q <= start_i;
            beat_q  <= '0;
        end else if (advance_i) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    generate
        if (BURST_BITS > 0) begin : g_map
            always_comb begin
                if (order_i == ORD_INTERLEAVE)
                    low_o = start_q ^ beat_q;
                else
                    low_o = start_q + beat_q;
            end
        end
    endgenerate

    p_step_linear_r4: assert property (@(posedge clk) disable iff (rst)
        (advance_i && order_i == ORD_LINEAR) |=>
            low_o == BURST_BITS'($past(low_o) + 1'b1));

    p_step_ilv_r5: assert property (@(posedge clk) disable iff (rst)
        (advance_i && order_i == ORD_INTERLEAVE) |=>
            (low_o ^ $past(low_o)) == ($past(beat_q) ^ BURST_BITS'($past(beat_q) + 1'b1)));

    p_load_start_r8: assert property (@(posedge clk) disable iff (rst)
        load_i |=> low_o == $past(start_i));
endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic              cache_stb_n,
    input  logic              proc_stb_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs_hi_i,
    input  logic              cs_lo_n,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              selected_o
);
    localparam int UPPER_W = ADDR_W - BURST_BITS;

    step_ctrl_t            ctrl;
    logic [UPPER_W-1:0]    upper_q;
    logic [BURST_BITS-1:0] low;
    logic                  sel_q;
    order_e                order;

    assign order = order_e'(order_i);

    burst_load_ctrl u_ctrl (
        .sleep_i     (sleep_i),
        .cache_stb_n (cache_stb_n),
        .proc_stb_n  (proc_stb_n),
        .adv_n       (adv_n),
        .ce_n        (ce_n),
        .cs_hi_i     (cs_hi_i),
        .cs_lo_n     (cs_lo_n),
        .ctrl_o      (ctrl)
    );

    burst_seq #(.BURST_BITS(BURST_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctrl.load),
        .advance_i (ctrl.advance),
        .start_i   (addr_i[BURST_BITS-1:0]),
        .order_i   (order),
        .low_o     (low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            sel_q   <= 1'b0;
        end else if (ctrl.load) begin
            upper_q <= addr_i[ADDR_W-1:BURST_BITS];
            sel_q   <= ctrl.sel;
        end
    end

    assign addr_o     = {upper_q, low};
    assign selected_o = sel_q;

    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !cache_stb_n) |=> addr_o == $past(addr_i));

    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && cache_stb_n && ce_n && adv_n) |=> $stable(addr_o));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cache_stb_n && proc_stb_n && adv_n) |=> $stable(addr_o));

    p_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (cache_stb_n && (proc_stb_n || ce_n)) |=>
            $stable(addr_o[ADDR_W-1:BURST_BITS]));

    p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cache_stb_n && (proc_stb_n || ce_n)) |=> $stable(selected_o));

    p_sleep_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(addr_o) && $stable(selected_o)));
endmodule

// File: tb/tb_burst_addr_unit.sv
module tb_burst_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic          sleep_i, cache_stb_n, proc_stb_n, adv_n;
    logic          ce_n, cs_hi_i, cs_lo_n, order_i;
    logic [AW-1:0] addr_i;
    logic [AW-1:0] addr_o;
    logic          selected_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_unit dut (
        .clk(clk), .rst(rst), .sleep_i(sleep_i),
        .cache_stb_n(cache_stb_n), .proc_stb_n(proc_stb_n), .adv_n(adv_n),
        .ce_n(ce_n), .cs_hi_i(cs_hi_i), .cs_lo_n(cs_lo_n), .order_i(order_i),
        .addr_i(addr_i), .addr_o(addr_o), .selected_o(selected_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sleep_i = 0; cache_stb_n = 1; proc_stb_n = 1; adv_n = 1;
        ce_n = 1; cs_hi_i = 0; cs_lo_n = 1;
    endtask

    task automatic load_cache(input logic [AW-1:0] a);
        cache_stb_n = 0; ce_n = 0; cs_hi_i = 1; cs_lo_n = 0; addr_i = a;
        tick();
        idle();
    endtask

    task automatic step();
        adv_n = 0;
        tick();
        adv_n = 1;
    endtask

    task automatic t_reset();
        check("R10 addr", 32'(addr_o), 32'h0);
        check("R10 sel", 32'(selected_o), 32'h0);
    endtask

    task automatic t_cache_load();
        cache_stb_n = 0; ce_n = 1; addr_i = 17'h01235;
        tick(); idle();
        check("R1 cache load ce high", 32'(addr_o), 32'h01235);
        check("R7 sel with ce high", 32'(selected_o), 32'h0);
    endtask

    task automatic t_proc_gate();
        proc_stb_n = 0; ce_n = 1; addr_i = 17'h0ABC4;
        tick();
        check("R2 proc gated", 32'(addr_o), 32'h01235);
        ce_n = 0; cs_hi_i = 1; cs_lo_n = 0;
        tick(); idle();
        check("R2 proc load", 32'(addr_o), 32'h0ABC4);
        check("R7 sel set", 32'(selected_o), 32'h1);
    endtask

    task automatic t_linear();
        logic [1:0] seq [5] = '{2'd2, 2'd3, 2'd0, 2'd1, 2'd2};
        order_i = 0;
        load_cache(17'h10F02);
        check("R4 linear start", 32'(addr_o), 32'h10F02);
        for (int i = 1; i < 5; i++) begin
            step();
            check(i == 4 ? "R6 linear wrap" : "R4 linear step",
                  32'(addr_o), 32'h10F00 | 32'(seq[i]));
        end
    endtask

    task automatic t_interleave();
        logic [1:0] seq [5] = '{2'd1, 2'd0, 2'd3, 2'd2, 2'd1};
        order_i = 1;
        load_cache(17'h02221);
        check("R5 ilv start", 32'(addr_o), 32'h02221);
        for (int i = 1; i < 5; i++) begin
            step();
            check(i == 4 ? "R6 ilv wrap" : "R5 ilv step",
                  32'(addr_o), 32'h02220 | 32'(seq[i]));
        end
        order_i = 0;
    endtask

    task automatic t_hold();
        load_cache(17'h00300);
        tick(); tick();
        check("R3 hold idle", 32'(addr_o), 32'h00300);
        step();
        check("R3 one step", 32'(addr_o), 32'h00301);
        tick();
        check("R3 hold after step", 32'(addr_o), 32'h00301);
    endtask

    task automatic t_priority();
        load_cache(17'h00004);
        step();
        check("R8 pre step", 32'(addr_o), 32'h00005);
        cache_stb_n = 0; proc_stb_n = 0; ce_n = 0; adv_n = 0; addr_i = 17'h1FFF7;
        tick(); idle();
        check("R8 load wins", 32'(addr_o), 32'h1FFF7);
        step();
        check("R8 beat restart", 32'(addr_o), 32'h1FFF4);
    endtask

    task automatic t_select();
        cache_stb_n = 0; ce_n = 0; cs_hi_i = 0; cs_lo_n = 0; addr_i = 17'h00010;
        tick(); idle();
        check("R7 cs_hi low", 32'(selected_o), 32'h0);
        cache_stb_n = 0; ce_n = 0; cs_hi_i = 1; cs_lo_n = 1;
        tick(); idle();
        check("R7 cs_lo high", 32'(selected_o), 32'h0);
        cache_stb_n = 0; ce_n = 0; cs_hi_i = 1; cs_lo_n = 0;
        tick(); idle();
        check("R7 all select", 32'(selected_o), 32'h1);
        cs_hi_i = 0; ce_n = 1;
        step();
        check("R7 held over advance", 32'(selected_o), 32'h1);
        cache_stb_n = 0; ce_n = 1;
        tick(); idle();
        check("R7 cleared on load", 32'(selected_o), 32'h0);
    endtask

    task automatic t_sleep();
        load_cache(17'h04448);
        check("R9 pre sleep", 32'(addr_o), 32'h04448);
        sleep_i = 1; cache_stb_n = 0; proc_stb_n = 0; ce_n = 0;
        cs_hi_i = 0; adv_n = 0; addr_i = 17'h1AAAB;
        tick(); tick();
        check("R9 addr frozen", 32'(addr_o), 32'h04448);
        check("R9 sel frozen", 32'(selected_o), 32'h1);
        idle();
        step();
        check("R9 resume", 32'(addr_o), 32'h04449);
    endtask

    initial begin
        idle();
        order_i = 0; addr_i = '0; rst = 1;
        tick(); tick();
        rst = 0;
        t_reset();
        t_cache_load();
        t_proc_gate();
        t_linear();
        t_interleave();
        t_hold();
        t_priority();
        t_select();
        t_sleep();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule